// File: doc/BRIEF.md
# Single-Precision Compare with Sticky Condition Flag

This block compares two single-precision floating-point operands and keeps the outcome in a one-bit condition flag. It models the condition state of a floating-point coprocessor. A compare strobe, together with a mode select, picks between a strict less-than test and a less-or-equal test. On the next clock edge the flag takes the result of that test. The flag then keeps its value until another compare strobe arrives.

Branch logic later queries the flag through two strobes. One strobe takes the branch when the flag is set, and the other takes it when the flag is clear. The block also decodes each operand into its class (zero, denormal, normal, infinity or NaN) as a set of one-hot flags. Downstream logic can use these flags without decoding the fields again.

An operand is laid out as a sign in bit 31, a biased exponent in bits 30:23 and a fraction in bits 22:0. Ordering follows sign and magnitude. Zeros of either sign are equal. A NaN on either side makes every ordered test false.

Top module: `fp_cond_compare`

## Requirements
- R1: An operand whose exponent field (bits 30:23) is 0 is classed as zero (class bit 0) when its fraction (bits 22:0) is 0, and as denormal (class bit 1) when its fraction is nonzero.
- R2: An operand whose exponent field lies from 1 to 254 is classed as normal (class bit 2), whatever its fraction.
- R3: An operand whose exponent field is 255 is classed as infinity (class bit 3) when its fraction is 0, and as NaN (class bit 4) when its fraction is nonzero.
- R4: Each class output is combinational from its operand and always has exactly one of its five bits set.
- R5: When the compare strobe is high and the mode select is 0 (less-than), the flag seen after the next rising edge is 1 if A<B and 0 otherwise.
- R6: When the compare strobe is high and the mode select is 1 (less-or-equal), the flag seen after the next rising edge is 1 if A<=B and 0 otherwise.
- R7: If either operand is NaN, a compare in either mode clears the flag.
- R8: +0 (0x00000000) and -0 (0x80000000) compare equal: neither is less than the other, and each is less-or-equal to the other.
- R9: Ordering is by sign and magnitude. Any negative non-zero value is below any positive value. Positive values order by their bits 30:0. Negative values order with that magnitude reversed, so -infinity is the lowest value and +infinity the highest.
- R10: While the compare strobe is low, the flag keeps its value whatever the operands and the mode select do.
- R11: The taken output is combinational. It is 1 when the branch-if-true strobe is high and the current flag is 1, or when the branch-if-false strobe is high and the current flag is 0. It is 0 when neither strobe is high. A compare in the same cycle does not affect it.
- R12: While reset is asserted and just after it is released, the flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| cmp_en | input | 1 | Compare strobe; updates the flag at the next edge |
| cmp_le | input | 1 | Compare mode: 0 less-than, 1 less-or-equal |
| br_true | input | 1 | Branch-if-flag-set query |
| br_false | input | 1 | Branch-if-flag-clear query |
| flag | output | 1 | Sticky condition flag |
| taken | output | 1 | Branch decision for the current queries |
| cls_a | output | 5 | One-hot class of A: bit0 zero, bit1 denormal, bit2 normal, bit3 infinity, bit4 NaN |
| cls_b | output | 5 | One-hot class of B, same encoding as cls_a |

## Verification
The bench goes after the corners where floating-point order departs from plain integer order.

- Two negative operands: a design that compared raw bit patterns would order them backwards.
- A positive operand against a negative one: a design that ignored the sign would set the flag for the larger magnitude.
- +0 against -0: a design that skipped the zero case would report -0 as less than +0.
- Any NaN operand: a design without unordered handling would set the flag, because a NaN's magnitude is larger than that of infinity.
- The classifier boundaries (exponent 0, 1, 254 and 255, each with zero and nonzero fractions): a wrong boundary shows up as a second or missing class bit.
- Idle cycles after a compare, and branch queries issued in the same cycle as a compare: a flag that is not sticky, or a taken signal that looks at the new result, would fail here.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    // Class bit positions on the one-hot class outputs
    localparam int CLS_ZERO   = 0;
    localparam int CLS_DENORM = 1;
    localparam int CLS_NORMAL = 2;
    localparam int CLS_INF    = 3;
    localparam int CLS_NAN    = 4;
    localparam int CLS_N      = 5;

    // Registered state of the block
    typedef struct packed {
        logic flag;
    } cc_state_t;

endpackage

// File: rtl/fp_class_decode.sv
module fp_class_decode
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [CLS_N-1:0]  cls_o
);

    logic exp_all0;
    logic exp_all1;
    logic frac_nz;

    always_comb begin
        exp_all0 = (exp_i == '0);
        exp_all1 = &exp_i;
        frac_nz  = |frac_i;
        cls_o    = '0;
        if (exp_all0) begin
            cls_o[CLS_ZERO]   = !frac_nz;
            cls_o[CLS_DENORM] = frac_nz;
        end else if (exp_all1) begin
            cls_o[CLS_INF]    = !frac_nz;
            cls_o[CLS_NAN]    = frac_nz;
        end else begin
            cls_o[CLS_NORMAL] = 1'b1;
        end
    end

endmodule

// File: rtl/fp_order_unit.sv
module fp_order_unit #(
    parameter int MAG_W = 31
) (
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             unordered,
    input  logic             both_zero,
    output logic             lt_o,
    output logic             eq_o
);

    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = (mag_a < mag_b);
        mag_eq = (mag_a == mag_b);
        if (unordered) begin
            lt_o = 1'b0;
            eq_o = 1'b0;
        end else if (both_zero) begin
            lt_o = 1'b0;
            eq_o = 1'b1;
        end else if (sign_a != sign_b) begin
            lt_o = sign_a;
            eq_o = 1'b0;
        end else if (!sign_a) begin
            lt_o = mag_lt;
            eq_o = mag_eq;
        end else begin
            lt_o = !mag_lt && !mag_eq;
            eq_o = mag_eq;
        end
    end

endmodule

// File: rtl/fp_cond_compare.sv
module fp_cond_compare
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int MAG_W = EXP_W + FRAC_W,
    localparam int W     = MAG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic             cmp_en,
    input  logic             cmp_le,
    input  logic             br_true,
    input  logic             br_false,
    output logic             flag,
    output logic             taken,
    output logic [CLS_N-1:0] cls_a,
    output logic [CLS_N-1:0] cls_b
);

    logic [W-1:0]     opnd [2];
    logic [CLS_N-1:0] cls  [2];
    logic             lt;
    logic             eq;
    cc_state_t        st_d;
    cc_state_t        st_q;

    assign opnd[0] = opa;
    assign opnd[1] = opb;

    for (genvar i = 0; i < 2; i++) begin : g_dec
        fp_class_decode #(
            .EXP_W (EXP_W),
            .FRAC_W(FRAC_W)
        ) u_dec (
            .exp_i (opnd[i][W-2 -: EXP_W]),
            .frac_i(opnd[i][FRAC_W-1:0]),
            .cls_o (cls[i])
        );
    end

    assign cls_a = cls[0];
    assign cls_b = cls[1];

    fp_order_unit #(
        .MAG_W(MAG_W)
    ) u_ord (
        .sign_a   (opa[W-1]),
        .sign_b   (opb[W-1]),
        .mag_a    (opa[MAG_W-1:0]),
        .mag_b    (opb[MAG_W-1:0]),
        .unordered(cls[0][CLS_NAN] | cls[1][CLS_NAN]),
        .both_zero(cls[0][CLS_ZERO] & cls[1][CLS_ZERO]),
        .lt_o     (lt),
        .eq_o     (eq)
    );

    always_comb begin
        st_d = st_q;
        if (cmp_en) begin
            st_d.flag = lt | (cmp_le & eq);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag  = st_q.flag;
    assign taken = (br_true & st_q.flag) | (br_false & ~st_q.flag);

    assert_class_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cls_a) == 1) && ($countones(cls_b) == 1));

    assert_less_irreflexive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !cmp_le && opa == opb) |=> !flag);

    assert_le_reflexive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && cmp_le && opa == opb && !cls_a[CLS_NAN]) |=> flag);

    assert_nan_unordered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && (cls_a[CLS_NAN] || cls_b[CLS_NAN])) |=> !flag);

    assert_signed_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && cmp_le && cls_a[CLS_ZERO] && cls_b[CLS_ZERO]) |=> flag);

    assert_neg_below_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && opa[W-1] && !opb[W-1] && !cls_a[CLS_NAN] && !cls_b[CLS_NAN]
         && !(cls_a[CLS_ZERO] && cls_b[CLS_ZERO])) |=> flag);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(flag));

    assert_both_queries_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (br_true && br_false) |-> taken);

endmodule

// File: tb/fp_cond_compare_test.sv
module fp_cond_compare_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        cmp_en = 1'b0;
    logic        cmp_le = 1'b0;
    logic        br_true = 1'b0;
    logic        br_false = 1'b0;
    logic        flag;
    logic        taken;
    logic [4:0]  cls_a;
    logic [4:0]  cls_b;

    int n_vec  = 0;
    int n_fail = 0;
    logic model_flag = 1'b0;

    always #5 clk = ~clk;

    fp_cond_compare uut (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb),
        .cmp_en(cmp_en), .cmp_le(cmp_le), .br_true(br_true), .br_false(br_false),
        .flag(flag), .taken(taken), .cls_a(cls_a), .cls_b(cls_b)
    );

    logic [31:0] specials [14] = '{
        32'h00000000, 32'h80000000, 32'h00000001, 32'h807FFFFF,
        32'h3F800000, 32'hBF800000, 32'h40000000, 32'hC0000000,
        32'h7F7FFFFF, 32'h7F800000, 32'hFF800000, 32'h7FC00000,
        32'hFF800001, 32'h00800000
    };

    function automatic logic is_nan(logic [31:0] v);
        return (v[30:23] == 8'd255) && (v[22:0] != 0);
    endfunction

    function automatic longint order_key(logic [31:0] v);
        longint m;
        m = longint'(v[30:0]);
        return v[31] ? -m : m;
    endfunction

    function automatic logic [4:0] ref_class(logic [31:0] v);
        int e;
        e = int'(v[30:23]);
        if (e == 0)        return (v[22:0] == 0) ? 5'b00001 : 5'b00010;
        else if (e == 255) return (v[22:0] == 0) ? 5'b01000 : 5'b10000;
        else               return 5'b00100;
    endfunction

    function automatic string class_req(logic [31:0] v);
        int e;
        e = int'(v[30:23]);
        if (e == 0)        return "R1";
        else if (e == 255) return "R3";
        else               return "R2";
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [31:0] b, logic en, logic le,
                         logic bt, logic bf);
        logic  res;
        string req;
        opa = a; opb = b; cmp_en = en; cmp_le = le; br_true = bt; br_false = bf;
        #2;
        check(class_req(a), "cls_a", 32'(cls_a), 32'(ref_class(a)));
        check(class_req(b), "cls_b", 32'(cls_b), 32'(ref_class(b)));
        check("R4", "onehot", 32'($countones({cls_a, 3'b0}) + $countones({cls_b, 3'b0})), 32'd2);
        check("R11", "taken", 32'(taken), 32'((bt & model_flag) | (bf & ~model_flag)));
        if (is_nan(a) || is_nan(b)) begin
            res = 1'b0; req = "R7";
        end else begin
            res = (order_key(a) < order_key(b)) || (le && order_key(a) == order_key(b));
            if (order_key(a) == 0 && order_key(b) == 0 && a != b) req = "R8";
            else if (a[31] || b[31])                          req = "R9";
            else                                                  req = le ? "R6" : "R5";
        end
        if (!en) req = "R10";
        @(posedge clk);
        if (en) model_flag = res;
        @(negedge clk);
        check(req, "flag", 32'(flag), 32'(model_flag));
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12", "flag in reset", 32'(flag), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "flag after reset", 32'(flag), 32'd0);

        // R5 and R6 on positives, including equal operands
        apply(32'h3F800000, 32'h40000000, 1, 0, 0, 0);
        apply(32'h40000000, 32'h3F800000, 1, 0, 0, 0);
        apply(32'h3F800000, 32'h3F800000, 1, 0, 0, 0);
        apply(32'h3F800000, 32'h3F800000, 1, 1, 0, 0);
        // R8 signed zeros in both modes and orders
        apply(32'h80000000, 32'h00000000, 1, 0, 0, 0);
        apply(32'h00000000, 32'h80000000, 1, 1, 0, 0);
        apply(32'h80000000, 32'h00000000, 1, 1, 0, 0);
        // R9 negatives reversed, mixed signs, infinities
        apply(32'hC0000000, 32'hBF800000, 1, 0, 0, 0);
        apply(32'hBF800000, 32'hC0000000, 1, 0, 0, 0);
        apply(32'hBF800000, 32'h00000001, 1, 0, 0, 0);
        apply(32'hFF800000, 32'h807FFFFF, 1, 0, 0, 0);
        apply(32'h7F7FFFFF, 32'h7F800000, 1, 1, 0, 0);
        // R7 NaN on either side after flag was set
        apply(32'h7FC00000, 32'h3F800000, 1, 1, 0, 0);
        apply(32'h00000000, 32'h3F800000, 1, 0, 0, 0);
        apply(32'h00000000, 32'hFF800001, 1, 1, 0, 0);
        // R10 hold flag=1 across idle cycles with operands that would clear it
        apply(32'h00000001, 32'h00000002, 1, 0, 0, 0);
        apply(32'h7FC00000, 32'h00000000, 0, 1, 0, 0);
        apply(32'h40000000, 32'h3F800000, 0, 0, 0, 0);
        // R11 queries, including same-cycle compare and both strobes
        apply(32'h40000000, 32'h3F800000, 1, 0, 1, 0);
        apply(32'h3F800000, 32'h3F800000, 0, 0, 1, 0);
        apply(32'h3F800000, 32'h3F800000, 0, 0, 0, 1);
        apply(32'h3F800000, 32'h3F800000, 0, 0, 1, 1);
        // Classifier boundaries R1 R2 R3
        apply(32'h00800000, 32'h7F000000, 0, 0, 0, 0);
        apply(32'h7F7FFFFF, 32'hFF800000, 0, 0, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            logic [3:0]  r;
            r = 4'($urandom);
            a = r[0] ? specials[$urandom % 14] : $urandom;
            b = r[1] ? specials[$urandom % 14] : $urandom;
            if (r[2] && r[3]) b = a;
            else if (r[2]) b = {~a[31], a[30:0]};
            apply(a, b, ($urandom % 4) != 0, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule